// File: doc/BRIEF.md
# Contrast PWM generator

This block produces a pulse-width-modulated level for a panel contrast or backlight pin. A small register port holds two words. The control word picks a clock divider of 1, 2, 4 or 8, an output inversion and an enable. The duty word is 8 bits and sets how many of the 256 prescaled ticks in each period drive the output to its active level.

Out of reset the block is already running. It divides by 8, does not invert, and uses a duty of 0xC8, which gives a medium brightness with no software set-up. Software changes the brightness by writing the duty word. The new value is held back until the current period ends, so a period never mixes two duty values. Writing zero to the control word parks the output at its inactive level.

Top module: `contrast_pwm`

## Requirements
- R1: After reset the duty word reads 0xC8 and the control word reads 0x0B. That value means divide code 3 (divide by 8), no inversion, enabled.
- R2: `reg_sel`=0 addresses the control word and `reg_sel`=1 addresses the duty word. A write happens on a clock edge with `reg_wr` high. The control word uses bits [1:0] as the divide code (0..3 gives 1, 2, 4, 8), bit 2 as invert and bit 3 as enable. Its upper bits read back as 0. `reg_rdata` always shows the selected word.
- R3: While enabled, an 8-bit counter advances once every 2^code clock cycles, so one period lasts 256 × 2^code cycles.
- R4: With invert clear, the output is high while the counter is below the active duty. That gives duty × 2^code high cycles per period.
- R5: With invert set, the output is the complement of the R4 output. The active level is then low.
- R6: While the enable bit is clear, the output holds the inactive level: 0 without invert, 1 with invert. Writing 0 to the control word gives a constant low output. The counters are held at zero, so enabling starts a fresh period at the current duty.
- R7: A duty of 0 never drives the active level. A duty of 0xFF drives it for 255 of every 256 ticks.
- R8: A duty write made while running takes effect only when the counter wraps from 0xFF to 0. The period in progress completes with the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control, 1 duty |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pwm_out | output | 1 | PWM output to the panel pin |

## Verification
The hardest case to reach is a duty write that lands in the middle of a running period. Seen from the pins, an immediate update and a deferred update look the same unless the write falls after the output has dropped but before the counter wraps. The stimulus uses divide-by-1 and a small duty. It watches for the falling edge of the output and writes a larger duty right after it. It then requires the output to stay low for the rest of that period, and the next high pulse to have exactly the new length.

// File: rtl/contrast_pwm.sv
module contrast_pwm #(
  parameter int DUTY_W  = 8,
  parameter int PRESC_W = 2,
  parameter logic [DUTY_W-1:0]  DUTY_RST = 8'hC8,
  parameter logic [PRESC_W+1:0] CTRL_RST = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [DUTY_W-1:0] reg_wdata,
  output logic [DUTY_W-1:0] reg_rdata,
  output logic              pwm_out
);
  localparam int CTRL_W = PRESC_W + 2;
  localparam int PRE_W  = (1 << PRESC_W) - 1;

  logic [CTRL_W-1:0]  ctrl_reg;
  logic [DUTY_W-1:0]  duty_reg, duty_act, cnt;
  logic [PRE_W-1:0]   pre_cnt, pre_mask;
  logic [PRESC_W-1:0] ctrl_code;
  logic               ctrl_inv, ctrl_en, tick, wrap;

  assign ctrl_code = ctrl_reg[PRESC_W-1:0];
  assign ctrl_inv  = ctrl_reg[PRESC_W];
  assign ctrl_en   = ctrl_reg[PRESC_W+1];
  assign pre_mask  = ~({PRE_W{1'b1}} << ctrl_code);
  assign tick      = ctrl_en && ((pre_cnt & pre_mask) == pre_mask);
  assign wrap      = tick && (cnt == '1);
  assign reg_rdata = reg_sel ? duty_reg : DUTY_W'(ctrl_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_reg <= CTRL_RST;
      duty_reg <= DUTY_RST;
    end else if (reg_wr) begin
      if (reg_sel) duty_reg <= reg_wdata;
      else         ctrl_reg <= reg_wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      cnt      <= '0;
      duty_act <= DUTY_RST;
      pwm_out  <= 1'b0;
    end else begin
      if (!ctrl_en) begin
        pre_cnt  <= '0;
        cnt      <= '0;
        duty_act <= duty_reg;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
        if (tick) cnt <= cnt + 1'b1;
        if (wrap) duty_act <= duty_reg;
      end
      pwm_out <= ctrl_en ? ((cnt < duty_act) ^ ctrl_inv) : ctrl_inv;
    end
  end

  assert_disabled_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(ctrl_en) |-> pwm_out == $past(ctrl_inv));

  assert_zero_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(duty_act) == '0 |-> pwm_out == $past(ctrl_inv));

  assert_duty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ctrl_en && !wrap) |-> $stable(duty_act));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en && tick |=> cnt == $past(cnt) + 1'b1);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en && !tick && !reg_wr |=> $stable(cnt));
endmodule

// File: tb/tb_contrast_pwm.sv
`timescale 1ns/1ps
module tb_contrast_pwm;
  logic clk = 1'b0, rst_n = 1'b0, reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic pwm_out;
  int n_tests = 0, n_fail = 0;

  typedef struct { int high; int total; logic lvl; string tag; } win_t;
  win_t exp_q[$];
  event mon_done;

  always #2 clk = ~clk;

  contrast_pwm dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
                    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_sel = sel; #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic setup(input logic [7:0] ctrl, input logic [7:0] duty);
    wr(1'b0, 8'h00); wr(1'b1, duty); wr(1'b0, ctrl);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_win(input int high, input int total, input logic lvl, input string tag);
    win_t w;
    w.high = high; w.total = total; w.lvl = lvl; w.tag = tag;
    exp_q.push_back(w);
    @(mon_done);
  endtask

  initial begin : monitor
    forever begin
      win_t w;
      int c;
      wait (exp_q.size() > 0);
      w = exp_q.pop_front();
      c = 0;
      repeat (w.total) begin
        @(negedge clk);
        if (pwm_out == w.lvl) c++;
      end
      check(c == w.high, w.tag, c, w.high);
      ->mon_done;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : driver
    int run;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R1 output in reset", pwm_out, 0);
    rst_n = 1'b1;
    rd(1'b0, 8'h0B, "R1 control reset value");
    rd(1'b1, 8'hC8, "R1 duty reset value");
    repeat (4) @(negedge clk);
    expect_win(200 * 8, 256 * 8, 1'b1, "R3 R4 default div8 duty C8");

    setup(8'h08, 8'h40);
    expect_win(64, 256, 1'b1, "R3 div1 duty 40");
    setup(8'h09, 8'h40);
    expect_win(128, 512, 1'b1, "R3 div2 duty 40");
    setup(8'h0A, 8'h33);
    expect_win(204, 1024, 1'b1, "R4 div4 duty 33");

    setup(8'h0D, 8'h40);
    expect_win(128, 512, 1'b0, "R5 inverted div2 duty 40");

    wr(1'b0, 8'h00); repeat (2) @(negedge clk);
    expect_win(0, 300, 1'b1, "R6 control zero output low");
    wr(1'b0, 8'h04); repeat (2) @(negedge clk);
    expect_win(0, 300, 1'b0, "R6 disabled inverted output high");
    rd(1'b0, 8'h04, "R2 control readback");

    setup(8'h08, 8'h00);
    expect_win(0, 256, 1'b1, "R7 duty zero");
    setup(8'h08, 8'hFF);
    expect_win(255, 256, 1'b1, "R7 duty FF");
    rd(1'b1, 8'hFF, "R2 duty readback");
    wr(1'b0, 8'hF8);
    rd(1'b0, 8'h08, "R2 control upper bits read zero");

    setup(8'h08, 8'h10);
    @(negedge clk);
    while (pwm_out != 1'b1) @(negedge clk);
    while (pwm_out != 1'b0) @(negedge clk);
    wr(1'b1, 8'h80);
    run = 0;
    repeat (150) begin
      @(negedge clk);
      if (pwm_out) run++;
    end
    check(run == 0, "R8 old duty holds until wrap", run, 0);
    while (pwm_out != 1'b1) @(negedge clk);
    run = 0;
    while (pwm_out == 1'b1) begin
      run++;
      @(negedge clk);
    end
    check(run == 128, "R8 new duty after wrap", run, 128);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule